// File: doc/BRIEF.md
# Ethernet Port Interrupt Controller with Receive Coalescing

This block collects single-cycle event pulses from one fast Ethernet MAC port into a raw status register. It gates them through a per-source enable mask and two further enable levels, a port level and a global level, and presents the result as one registered interrupt line. Software services the port through a small register port. It reads status, clears bits by writing ones, and programs the enables and the coalescing setup.

Receive handling has two status views. The per-frame ready bit stays asserted while any received frame has not yet been consumed. Each write-one-to-clear of that bit consumes exactly one frame. The coalesced receive bit rises once per batch of frames. A batch ends when a programmed number of frames has arrived since the last batch. It also ends when a timer, started by the first frame of the batch and advanced once every `PRESCALE` clock cycles, reaches its programmed limit while frames are pending.

Top module: `eth_irq_coalesce`

## Requirements
- R1: After reset the status and enable registers read 0, the coalescing register reads 0x0800_0074 (threshold 8, timer limit 0x74), and `irq` is 0.
- R2: Register map, selected by `reg_addr`. Address 0 is status: bit 0 receive frame ready, bit 1 transmit packet done, bit 6 transmit FIFO empty, bit 7 coalesced receive. Address 1 is enable: bits 7:0 per-source, bit 18 port level, bit 19 global level. Address 2 is coalescing: bits 31:24 frame threshold, bits TMR_W-1:0 timer limit. Address 3 and all unimplemented bits read 0. Read data is combinational.
- R3: A pulse on `ev_tx_pkt` or `ev_tx_empty` sets status bit 1 or bit 6 respectively, visible after the next clock edge. Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R4: When an event arrives in the same cycle as a write-one-to-clear of its bit, the bit stays set.
- R5: Status bit 0 reads 1 while the count of unconsumed frames is nonzero. Each `ev_rx_frame` pulse adds one frame. Each write of 1 to bit 0 removes one frame, if any are pending.
- R6: When the number of frames since the last coalesced event reaches the threshold, status bit 7 is set after that frame's clock edge and the frame count restarts. A threshold of 0 acts as 1.
- R7: The first frame after a coalesced event arms the timer. The timer advances by one every PRESCALE cycles. When it reaches the limit, bit 7 is set on the following edge: with PRESCALE=4 and limit 5, this is the 21st edge after the arming frame's edge. After firing, the timer stays idle until the next frame.
- R8: `irq` is a register, updated each edge to the OR over status bits ANDed with their per-source enables, further ANDed with the port and global enables.
- R9: Writes to the enable and coalescing registers take effect at the next clock edge and read back masked to their implemented bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the selected register |
| ev_rx_frame | input | 1 | One frame received (pulse) |
| ev_tx_pkt | input | 1 | One packet transmitted (pulse) |
| ev_tx_empty | input | 1 | Transmit FIFO drained (pulse) |
| irq | output | 1 | Interrupt request level |

## Verification
Directed sequences separate the two ways a coalesced event can fire. A frame burst with a huge timer limit fires only on the count, and a single frame with a large threshold fires only on the timeout, on an exact edge. A follow-up wait confirms that the timer idles. Events collide with clears of the same bit, and frames are consumed one by one, which distinguishes a counter from a flag. Enables are opened level by level, so a missing level or an unregistered output shows up. A seeded random phase then mixes all events, clears, enable changes and short coalescing settings, and compares every read and every cycle of `irq` against a bench model.

// File: rtl/eth_irq_coalesce.sv
module eth_irq_coalesce #(
  parameter int PRESCALE = 16,
  parameter int TMR_W    = 16,
  parameter int PEND_W   = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        ev_rx_frame,
  input  logic        ev_tx_pkt,
  input  logic        ev_tx_empty,
  output logic        irq
);

  localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PEND_W-1:0] PEND_MAX = '1;
  localparam logic [7:0] THR_RST = 8'd8;
  localparam logic [TMR_W-1:0] TMR_RST = TMR_W'('h74);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);

  logic [PEND_W-1:0] pend_q;
  logic              b_txp, b_txe, b_coal;
  logic [7:0]        en_src;
  logic              en_port, en_glb;
  logic [7:0]        thr_q, coal_cnt;
  logic [TMR_W-1:0]  tlim_q, tmr_q;
  logic [PRE_W-1:0]  pre_q;

  wire       wr_raw = reg_wr && reg_addr == 2'd0;
  wire       wr_en  = reg_wr && reg_addr == 2'd1;
  wire       wr_cfg = reg_wr && reg_addr == 2'd2;
  wire [7:0] clr    = wr_raw ? reg_wdata[7:0] : 8'h00;

  wire [7:0] raw = {b_coal, b_txe, 4'b0000, b_txp, pend_q != '0};

  wire pend_inc = ev_rx_frame && pend_q != PEND_MAX;
  wire pend_dec = clr[0] && pend_q != '0;

  wire [7:0] thr_eff  = (thr_q == 8'd0) ? 8'd1 : thr_q;
  wire       armed    = coal_cnt != 8'd0;
  wire       fire_cnt = ev_rx_frame && ({1'b0, coal_cnt} + 9'd1 >= {1'b0, thr_eff});
  wire       fire_tmo = armed && tmr_q >= tlim_q;
  wire       fire     = fire_cnt || fire_tmo;
  wire       tick     = pre_q == PRE_LAST;

  logic unused_wdata;
  assign unused_wdata = ^{reg_wdata[23:20], reg_wdata[17:16]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      b_txp  <= 1'b0;
      b_txe  <= 1'b0;
      b_coal <= 1'b0;
    end else begin
      pend_q <= pend_q + PEND_W'(pend_inc) - PEND_W'(pend_dec);
      b_txp  <= ev_tx_pkt   | (b_txp  & ~clr[1]);
      b_txe  <= ev_tx_empty | (b_txe  & ~clr[6]);
      b_coal <= fire        | (b_coal & ~clr[7]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_src  <= 8'h00;
      en_port <= 1'b0;
      en_glb  <= 1'b0;
      thr_q   <= THR_RST;
      tlim_q  <= TMR_RST;
    end else begin
      if (wr_en) begin
        en_src  <= reg_wdata[7:0];
        en_port <= reg_wdata[18];
        en_glb  <= reg_wdata[19];
      end
      if (wr_cfg) begin
        thr_q  <= reg_wdata[31:24];
        tlim_q <= reg_wdata[TMR_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      coal_cnt <= 8'd0;
      tmr_q    <= '0;
      pre_q    <= '0;
    end else if (fire) begin
      coal_cnt <= 8'd0;
      tmr_q    <= '0;
      pre_q    <= '0;
    end else begin
      coal_cnt <= coal_cnt + 8'(ev_rx_frame);
      if (armed) begin
        pre_q <= tick ? '0 : pre_q + PRE_W'(1);
        if (tick) tmr_q <= tmr_q + TMR_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= en_glb && en_port && |(raw & en_src);
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = {24'h0, raw};
      2'd1:    reg_rdata = {12'h0, en_glb, en_port, 10'h0, en_src};
      2'd2:    reg_rdata = {thr_q, {(24 - TMR_W){1'b0}}, tlim_q};
      default: reg_rdata = 32'h0;
    endcase
  end

  assert_irq_needs_levels_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(en_glb && en_port));

  assert_w1c_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_raw && reg_wdata[1] && !ev_tx_pkt) |=> !b_txp);

  assert_zero_write_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_raw && reg_wdata[7:0] == 8'h00 && !ev_rx_frame && !ev_tx_pkt && !ev_tx_empty && !fire)
      |=> $stable(raw));

  assert_event_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tx_empty |=> b_txe);

  assert_frame_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rx_frame |=> pend_q != '0);

  assert_coal_on_fire_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (b_coal && coal_cnt == 8'd0));

endmodule

// File: tb/eth_irq_coalesce_bench.sv
`timescale 1ns/1ps
module eth_irq_coalesce_bench;
  localparam int PRE = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = 32'h0;
  logic [31:0] reg_rdata;
  logic        ev_rx_frame = 1'b0, ev_tx_pkt = 1'b0, ev_tx_empty = 1'b0;
  logic        irq;

  eth_irq_coalesce #(.PRESCALE(PRE), .TMR_W(16), .PEND_W(8)) u_eth_irq_coalesce (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_rx_frame(ev_rx_frame),
    .ev_tx_pkt(ev_tx_pkt), .ev_tx_empty(ev_tx_empty), .irq(irq));

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0;
  bit running = 1'b0;

  // bench model of the requirements
  int unsigned m_pend, m_cc, m_tmr, m_pre;
  logic m_b1, m_b6, m_b7, m_irq;
  logic [7:0] m_en_src, m_thr, m_clr, m_raw;
  logic m_port, m_glb, m_fc, m_ft;
  logic [15:0] m_tlim;

  function automatic logic [7:0] model_raw();
    return {m_b7, m_b6, 4'b0, m_b1, m_pend != 0};
  endfunction

  function automatic logic [31:0] model_read(logic [1:0] a);
    case (a)
      2'd0: return {24'h0, model_raw()};
      2'd1: return {12'h0, m_glb, m_port, 10'h0, m_en_src};
      2'd2: return {m_thr, 8'h0, m_tlim};
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pend = 0; m_cc = 0; m_tmr = 0; m_pre = 0;
      m_b1 = 0; m_b6 = 0; m_b7 = 0; m_irq = 0;
      m_en_src = 0; m_port = 0; m_glb = 0; m_thr = 8; m_tlim = 16'h74;
    end else begin
      m_raw = model_raw();
      m_irq = m_glb && m_port && |(m_raw & m_en_src);
      m_clr = (reg_wr && reg_addr == 2'd0) ? reg_wdata[7:0] : 8'h0;
      m_fc = ev_rx_frame && (m_cc + 1 >= ((m_thr == 0) ? 1 : m_thr));
      m_ft = (m_cc != 0) && (m_tmr >= m_tlim);
      m_pend = m_pend + ((ev_rx_frame && m_pend != 255) ? 1 : 0) - ((m_clr[0] && m_pend != 0) ? 1 : 0);
      m_b1 = ev_tx_pkt | (m_b1 & ~m_clr[1]);
      m_b6 = ev_tx_empty | (m_b6 & ~m_clr[6]);
      m_b7 = m_fc | m_ft | (m_b7 & ~m_clr[7]);
      if (m_fc || m_ft) begin
        m_cc = 0; m_tmr = 0; m_pre = 0;
      end else begin
        if (m_cc != 0) begin
          if (m_pre == PRE - 1) begin m_pre = 0; m_tmr = m_tmr + 1; end
          else m_pre = m_pre + 1;
        end
        m_cc = m_cc + (ev_rx_frame ? 1 : 0);
      end
      if (reg_wr && reg_addr == 2'd1) begin
        m_en_src = reg_wdata[7:0]; m_port = reg_wdata[18]; m_glb = reg_wdata[19];
      end
      if (reg_wr && reg_addr == 2'd2) begin
        m_thr = reg_wdata[31:24]; m_tlim = reg_wdata[15:0];
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (running) chk("R8 irq vs model", {31'h0, irq}, {31'h0, m_irq});

  task automatic cyc(); @(negedge clk); endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    cyc();
    reg_wr = 1'b0;
  endtask

  task automatic rd(string tag, logic [1:0] a, logic [31:0] mask, logic [31:0] exp);
    reg_addr = a;
    #0.5;
    chk(tag, reg_rdata & mask, exp);
  endtask

  task automatic frame();
    ev_rx_frame = 1'b1; cyc(); ev_rx_frame = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int unsigned sel;
    void'($urandom(32'd20240611));
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();
    running = 1'b1;

    // R1 reset state
    rd("R1 status", 2'd0, 32'hFFFFFFFF, 32'h0);
    rd("R1 enable", 2'd1, 32'hFFFFFFFF, 32'h0);
    rd("R1 coalesce", 2'd2, 32'hFFFFFFFF, 32'h0800_0074);
    chk("R1 irq", {31'h0, irq}, 32'h0);

    // R3 set, zero-write, clear
    ev_tx_pkt = 1'b1; cyc(); ev_tx_pkt = 1'b0;
    rd("R3 tx pkt set", 2'd0, 32'hFFFFFFFF, 32'h2);
    wr(2'd0, 32'h0);
    rd("R3 zero write keeps", 2'd0, 32'hFFFFFFFF, 32'h2);
    wr(2'd0, 32'h2);
    rd("R3 w1c clears", 2'd0, 32'hFFFFFFFF, 32'h0);

    // R4 event beats clear
    ev_tx_empty = 1'b1; wr(2'd0, 32'h40); ev_tx_empty = 1'b0;
    rd("R4 event wins", 2'd0, 32'hFFFFFFFF, 32'h40);
    wr(2'd0, 32'h40);

    // R2 / R9 masked readback
    wr(2'd1, 32'hFFFFFFFF);
    rd("R9 enable readback", 2'd1, 32'hFFFFFFFF, 32'h000C_00FF);
    wr(2'd1, 32'h0);
    wr(2'd2, 32'hFFFFFFFF);
    rd("R9 coalesce readback", 2'd2, 32'hFFFFFFFF, 32'hFF00_FFFF);
    rd("R2 addr3 zero", 2'd3, 32'hFFFFFFFF, 32'h0);

    // R6 count threshold
    wr(2'd2, 32'h0300_FFFF);
    frame(); rd("R6 after 1 frame", 2'd0, 32'h80, 32'h0);
    frame(); rd("R6 after 2 frames", 2'd0, 32'h80, 32'h0);
    frame(); rd("R6 after 3 frames", 2'd0, 32'h80, 32'h80);
    wr(2'd0, 32'h80);
    wr(2'd2, 32'h0000_FFFF);
    frame(); rd("R6 threshold zero", 2'd0, 32'h80, 32'h80);
    wr(2'd0, 32'h80);

    // R5 pending frames: four pending
    wr(2'd0, 32'h1); wr(2'd0, 32'h1); wr(2'd0, 32'h1);
    rd("R5 one frame left", 2'd0, 32'h1, 32'h1);
    wr(2'd0, 32'h1);
    rd("R5 all consumed", 2'd0, 32'h1, 32'h0);
    wr(2'd0, 32'hFF);

    // R7 timeout: limit 5, prescale 4
    wr(2'd2, 32'h6400_0005);
    frame();
    repeat (20) cyc();
    rd("R7 before timeout", 2'd0, 32'h80, 32'h0);
    cyc();
    rd("R7 at timeout", 2'd0, 32'h80, 32'h80);
    wr(2'd0, 32'h80);
    repeat (30) cyc();
    rd("R7 timer idle", 2'd0, 32'h80, 32'h0);
    wr(2'd0, 32'hFF);

    // R8 enable levels
    ev_tx_empty = 1'b1; cyc(); ev_tx_empty = 1'b0;
    wr(2'd1, 32'h0000_0040);
    cyc(); cyc();
    chk("R8 no levels", {31'h0, irq}, 32'h0);
    wr(2'd1, 32'h000C_0040);
    chk("R8 registered delay", {31'h0, irq}, 32'h0);
    cyc();
    chk("R8 asserted", {31'h0, irq}, 32'h1);
    wr(2'd0, 32'h40);
    chk("R8 clear edge", {31'h0, irq}, 32'h1);
    cyc();
    chk("R8 deasserted", {31'h0, irq}, 32'h0);
    ev_tx_empty = 1'b1; cyc(); ev_tx_empty = 1'b0;
    wr(2'd1, 32'h0004_0040);
    cyc(); cyc();
    chk("R8 global off", {31'h0, irq}, 32'h0);
    wr(2'd0, 32'hFF);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      ev_rx_frame = ($urandom % 4) == 0;
      ev_tx_pkt   = ($urandom % 5) == 0;
      ev_tx_empty = ($urandom % 7) == 0;
      if (($urandom % 6) == 0) begin
        reg_wr = 1'b1;
        sel = $urandom % 10;
        if (sel < 6) begin
          reg_addr = 2'd0; reg_wdata = $urandom;
        end else if (sel < 8) begin
          reg_addr = 2'd1; reg_wdata = $urandom | ((($urandom % 3) != 0) ? 32'h000C_0000 : 32'h0);
        end else begin
          reg_addr = 2'd2; reg_wdata = {8'($urandom % 6), 8'h0, 16'($urandom % 12)};
        end
      end
      cyc();
      reg_wr = 1'b0; ev_rx_frame = 1'b0; ev_tx_pkt = 1'b0; ev_tx_empty = 1'b0;
      if (i % 3 == 0) begin
        sel = $urandom % 4;
        rd("R2 R5 R6 R7 random read", 2'(sel), 32'hFFFFFFFF, model_read(2'(sel)));
      end
    end

    running = 1'b0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule